// File: doc/BRIEF.md
# Masked Interrupt Status Unit

This block merges interrupt causes from a packet buffer allocator and from the receive and transmit paths of a network controller into one level-sensitive interrupt line. It keeps an 8-bit status register and an 8-bit enable mask. The host writes the mask directly. It acknowledges status bits by writing ones to them.

Two status bits follow live queue occupancy. The transmit-idle bit is forced on while the transmit queue is empty. The transmit-done bit is forced on while the completion queue still holds an entry. The remaining bits are sticky. Neighbouring logic sets them with event pulses, and they are cleared either by an acknowledge write (only the bits the acknowledge mask allows) or by explicit clear pulses from the path that owns them.

An acknowledge that includes the transmit-done bit also asks the completion queue to drop its head entry, using a one-cycle pop strobe. The status is evaluated every cycle, and the interrupt output is registered.

Top module: `intr_status_unit`

## Requirements
- R1: While reset is asserted, status reads 0x04, mask reads 0x00 and irq is low.
- R2: Status bit 2 (value 0x04, transmit idle) is set after every clock edge at which the transmit queue length was zero; an acknowledge of it takes effect only when the length is nonzero.
- R3: Status bit 1 (value 0x02, transmit done) is set after every clock edge at which the completion count, less any pop made in that cycle, was nonzero.
- R4: An acknowledge write clears exactly the status bits set in ack_data AND ACK_MASK (default 0xD6); bits 0, 3 and 5 are never cleared by it.
- R5: done_pop is high in the same cycle as an acknowledge write with bit 1 set, if and only if done_count is nonzero.
- R6: A bit requested on ev_set (bit 0 receive, bit 3 allocation, bit 4 receive overrun, others generic) is set after the next edge and stays set; a set wins over a same-cycle clear or acknowledge of that bit.
- R7: A bit requested on ev_clr is cleared after the next edge, unless it is set or forced in the same cycle.
- R8: A mask write loads mask_data after the next edge, and irq equals the OR of (status AND mask) for the values shown after every edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_len | input | QLEN_W | Current transmit queue length |
| done_count | input | QLEN_W | Current completion queue occupancy |
| ev_set | input | 8 | One-cycle requests to set status bits |
| ev_clr | input | 8 | One-cycle requests to clear status bits |
| ack_we | input | 1 | Acknowledge write strobe |
| ack_data | input | 8 | Write-one-to-clear value |
| mask_we | input | 1 | Mask write strobe |
| mask_data | input | 8 | New mask value |
| status | output | 8 | Interrupt status register |
| mask | output | 8 | Interrupt enable mask |
| irq | output | 1 | Registered interrupt level |
| done_pop | output | 1 | Request to drop the completion queue head |

## Verification
The bench uses the default parameters: QLEN_W of 3 and an acknowledge mask of 0xD6. These settings let it drive completion counts of 0 to 3, which covers the count-of-one boundary where a pop empties the queue and the empty case where an acknowledge must not pop. With the 0xD6 mask, the same all-ones acknowledge both clears bits and leaves bits 0, 3 and 5 untouched. A scoreboard model also exercises set-versus-clear collisions and mask changes that move irq with status held fixed.

// File: rtl/intr_pkg.sv
package intr_pkg;
  localparam int STAT_W  = 8;
  localparam int B_RCV   = 0;
  localparam int B_TX    = 1;
  localparam int B_TXE   = 2;
  localparam int B_ALLOC = 3;
  localparam int B_OVRN  = 4;

  typedef logic [STAT_W-1:0] stat_t;

  localparam stat_t RESET_STATUS = stat_t'(1) << B_TXE;

  // Bits held up by live queue state.
  function automatic stat_t live_bits(input logic tx_idle, input logic done_left);
    stat_t v;
    v = '0;
    v[B_TXE] = tx_idle;
    v[B_TX]  = done_left;
    return v;
  endfunction

  // Next status: clears first, then sets and live bits dominate.
  function automatic stat_t next_status(input stat_t cur, input stat_t ack_bits,
                                        input stat_t clr, input stat_t set,
                                        input stat_t live);
    return (cur & ~ack_bits & ~clr) | set | live;
  endfunction
endpackage

// File: rtl/intr_live.sv
module intr_live
  import intr_pkg::*;
#(
  parameter int QLEN_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [QLEN_W-1:0] tx_len,
  input  logic [QLEN_W-1:0] done_count,
  input  logic              ack_we,
  input  logic              ack_tx,
  output stat_t             live,
  output logic              done_pop
);
  logic done_nonempty;
  logic done_left;
  logic tx_idle;

  assign done_nonempty = (done_count != '0);
  assign done_pop      = ack_we & ack_tx & done_nonempty;
  assign done_left     = done_count > QLEN_W'(done_pop);
  assign tx_idle       = (tx_len == '0);
  assign live          = live_bits(tx_idle, done_left);

  AST_POP_NEEDS_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    done_pop |-> (done_count != '0)); // R5

  AST_POP_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    done_pop |-> (ack_we && ack_tx)); // R5
endmodule

// File: rtl/intr_status.sv
module intr_status
  import intr_pkg::*;
#(
  parameter stat_t ACK_MASK = 8'hD6
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ack_we,
  input  stat_t ack_data,
  input  stat_t ev_set,
  input  stat_t ev_clr,
  input  stat_t live,
  output stat_t status,
  output stat_t status_nxt
);
  stat_t ack_bits;
  stat_t status_q;

  assign ack_bits   = ack_we ? (ack_data & ACK_MASK) : '0;
  assign status_nxt = next_status(status_q, ack_bits, ev_clr, ev_set, live);
  assign status     = status_q;

  always_ff @(posedge clk) begin
    if (!rst_n) status_q <= RESET_STATUS;
    else        status_q <= status_nxt;
  end

  AST_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(ev_set) & ~status_q) == '0)); // R6

  AST_ACK_SCOPE: assert property (@(posedge clk) disable iff (!rst_n)
    ((~ACK_MASK & $past(status_q) & ~$past(ev_clr) & ~status_q) == '0)); // R4
endmodule

// File: rtl/intr_mask.sv
module intr_mask
  import intr_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  mask_we,
  input  stat_t mask_data,
  output stat_t mask,
  output stat_t mask_nxt
);
  stat_t mask_q;

  assign mask_nxt = mask_we ? mask_data : mask_q;
  assign mask     = mask_q;

  always_ff @(posedge clk) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_nxt;
  end

  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mask_we) |-> (mask_q == $past(mask_data))); // R8
endmodule

// File: rtl/intr_status_unit.sv
module intr_status_unit
  import intr_pkg::*;
#(
  parameter int    QLEN_W   = 3,
  parameter logic [7:0] ACK_MASK = 8'hD6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [QLEN_W-1:0] tx_len,
  input  logic [QLEN_W-1:0] done_count,
  input  logic [7:0]        ev_set,
  input  logic [7:0]        ev_clr,
  input  logic              ack_we,
  input  logic [7:0]        ack_data,
  input  logic              mask_we,
  input  logic [7:0]        mask_data,
  output logic [7:0]        status,
  output logic [7:0]        mask,
  output logic              irq,
  output logic              done_pop
);
  stat_t live;
  stat_t status_nxt;
  stat_t mask_nxt;
  logic  irq_q;

  intr_live #(.QLEN_W(QLEN_W)) u_live (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_len     (tx_len),
    .done_count (done_count),
    .ack_we     (ack_we),
    .ack_tx     (ack_data[B_TX]),
    .live       (live),
    .done_pop   (done_pop)
  );

  intr_status #(.ACK_MASK(ACK_MASK)) u_status (
    .clk        (clk),
    .rst_n      (rst_n),
    .ack_we     (ack_we),
    .ack_data   (ack_data),
    .ev_set     (ev_set),
    .ev_clr     (ev_clr),
    .live       (live),
    .status     (status),
    .status_nxt (status_nxt)
  );

  intr_mask u_mask (
    .clk       (clk),
    .rst_n     (rst_n),
    .mask_we   (mask_we),
    .mask_data (mask_data),
    .mask      (mask),
    .mask_nxt  (mask_nxt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |(status_nxt & mask_nxt);
  end
  assign irq = irq_q;

  AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    irq == |(status & mask)); // R8

  AST_TXE_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
    $past(tx_len == '0) |-> status[B_TXE]); // R2

  AST_TX_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(done_count) > QLEN_W'($past(done_pop))) |-> status[B_TX]); // R3
endmodule

// File: tb/intr_status_unit_bench.sv
module intr_status_unit_bench;
  localparam int PERIOD = 10;
  localparam int QW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [QW-1:0] tx_len = '0;
  logic [QW-1:0] done_count = '0;
  logic [7:0]    ev_set = '0, ev_clr = '0, ack_data = '0, mask_data = '0;
  logic          ack_we = 1'b0, mask_we = 1'b0;
  logic [7:0]    status, mask;
  logic          irq, done_pop;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [7:0] st;
    logic [7:0] mk;
    logic       iq;
    string      tag;
  } exp_t;
  exp_t sb[$];

  logic [7:0] m_status = 8'h04;
  logic [7:0] m_mask   = 8'h00;

  intr_status_unit #(.QLEN_W(QW), .ACK_MASK(8'hD6)) u_intr_status_unit (
    .clk(clk), .rst_n(rst_n), .tx_len(tx_len), .done_count(done_count),
    .ev_set(ev_set), .ev_clr(ev_clr), .ack_we(ack_we), .ack_data(ack_data),
    .mask_we(mask_we), .mask_data(mask_data), .status(status), .mask(mask),
    .irq(irq), .done_pop(done_pop)
  );

  always #(PERIOD/2) clk = ~clk;

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: compares the item pushed one cycle earlier.
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      check(status, e.st, {e.tag, " status"});
      check(mask, e.mk, {e.tag, " mask"});
      check({7'b0, irq}, {7'b0, e.iq}, {e.tag, " irq"});
    end
  end

  // Driver: called right after a falling edge.
  task automatic step(input logic [7:0] s, input logic [7:0] c, input logic aw,
                      input logic [7:0] ad, input logic mw, input logic [7:0] md,
                      input string tag);
    logic  pop_exp;
    exp_t  e;
    ev_set = s; ev_clr = c; ack_we = aw; ack_data = ad; mask_we = mw; mask_data = md;
    #1;
    pop_exp = aw && ad[1] && (done_count != 0);
    check({7'b0, done_pop}, {7'b0, pop_exp}, {tag, " R5 done_pop"});
    if (aw) m_status = m_status & ~(ad & 8'hD6);
    m_status = m_status & ~c;
    m_status = m_status | s;
    if (tx_len == 0) m_status[2] = 1'b1;
    if ((int'(done_count) - int'(pop_exp)) > 0) m_status[1] = 1'b1;
    if (mw) m_mask = md;
    e.st = m_status; e.mk = m_mask; e.iq = (m_status & m_mask) != 0; e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
    if (pop_exp) done_count = done_count - 1'b1;
    ev_set = '0; ev_clr = '0; ack_we = 1'b0; mask_we = 1'b0;
  endtask

  initial begin
    #(PERIOD*5000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(status, 8'h04, "R1 reset status");
    check(mask, 8'h00, "R1 reset mask");
    check({7'b0, irq}, 8'h00, "R1 reset irq");
    rst_n = 1'b1;
    @(negedge clk);
    step(8'h00, 8'h00, 0, 8'h00, 0, 8'h00, "R2 idle tx empty");
    step(8'h00, 8'h00, 0, 8'h00, 1, 8'hFF, "R8 mask all");
    tx_len = 3'd2;
    step(8'h00, 8'h00, 1, 8'h04, 0, 8'h00, "R2 ack txe busy");
    step(8'h19, 8'h00, 0, 8'h00, 0, 8'h00, "R6 set rcv alloc ovrn");
    step(8'h00, 8'h00, 1, 8'hFF, 0, 8'h00, "R4 ack all ones");
    step(8'h00, 8'h09, 0, 8'h00, 0, 8'h00, "R7 clear rcv alloc");
    step(8'h40, 8'h00, 1, 8'h40, 0, 8'h00, "R6 set beats ack");
    step(8'h80, 8'h80, 0, 8'h00, 0, 8'h00, "R6 set beats clear");
    step(8'h00, 8'h00, 0, 8'h00, 1, 8'h01, "R8 mask narrows");
    done_count = 3'd2;
    step(8'h00, 8'h00, 0, 8'h00, 0, 8'h00, "R3 done pending");
    step(8'h00, 8'h00, 1, 8'h02, 0, 8'h00, "R3 pop leaves one");
    step(8'h00, 8'h00, 1, 8'h02, 0, 8'h00, "R3 pop empties");
    step(8'h00, 8'h00, 1, 8'h02, 0, 8'h00, "R5 ack empty no pop");
    done_count = 3'd3;
    step(8'h00, 8'h00, 1, 8'hC0, 0, 8'h00, "R5 ack without tx bit");
    tx_len = 3'd0;
    step(8'h00, 8'h00, 0, 8'h00, 1, 8'h04, "R2 txe returns");
    step(8'h00, 8'h00, 1, 8'h04, 0, 8'h00, "R2 ack txe while idle");
    step(8'h20, 8'h00, 1, 8'hFF, 0, 8'h00, "R4 bit5 survives ack");
    @(negedge clk);
    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule